// File: doc/BRIEF.md
# Paging Control Register Unit

This block keeps the paging-related control state of a 32-bit x86-style core in one place. It holds three control registers, CR0, CR3 and CR4, together with the A20 address mask. It accepts register writes on a single valid/select/data port, and each write lands in the register at the clock edge that samples it. A separate level input gates address line 20.

From this state the unit produces translation-cache flush requests. Each request is a one-cycle pulse with a qualifier that tells whether the flush is full or keeps global entries. The unit also drives a small set of hidden mode flags, taken from CR0 and CR4, for the rest of the core. Register contents can be read back through a combinational select-addressed read port, and the current A20 mask is always visible on its own output.

The write port has no back-pressure. Every write that is presented is accepted in the cycle it appears. Writes come from a single source, so at most one register is written per cycle. A change on the gate input can coincide with a write, and the two flush causes are then merged.

Top module: `paging_ctrl_regs`

## Requirements
- R1: After reset, CR0 reads 0x60000010, CR3 and CR4 read 0, and the A20 mask is 0xFFFFFFFF. The flags are PE=0, ADDSEG=1, MP=EM=TS=0 and OSFXSR=0, and no flush pulse is raised.
- R2: The select value is shared by the write and read ports: 0 is CR0, 1 is CR3, 2 is CR4. A write with select 3 changes no register and raises no flush. A read with select 3 returns the A20 mask. A written value is visible on rd_data from the cycle after the write.
- R3: Bit 4 of CR0 is stored as 1 on every CR0 write, whatever the written data holds.
- R4: A CR0 write whose bit 31, 16 or 0 differs from the stored value raises flush_pulse with flush_full=1 in the cycle after the write.
- R5: hf_pe equals stored CR0 bit 0, and hf_addseg is 1 exactly when hf_pe is 0.
- R6: On every CR0 write, hf_mp, hf_em and hf_ts take the written bits 1, 2 and 3.
- R7: A CR3 write raises flush_pulse with flush_full=0 in the next cycle when stored CR0 bit 31 is 1. When that bit is 0, a CR3 write raises no flush.
- R8: A CR4 write that changes bit 7, 5 or 4 raises flush_pulse with flush_full=1 in the next cycle.
- R9: When sse_present is 0, CR4 bit 9 is stored as 0. hf_osfxsr always equals stored CR4 bit 9.
- R10: When a20_gate differs from mask bit 20, the mask becomes 0xFFEFFFFF with bit 20 set to the gate value, and a full flush pulse is raised in the next cycle. A steady gate raises nothing.
- R11: flush_pulse lasts one cycle per cause. A write that changes none of its trigger bits raises no pulse.
- R12: When causes coincide, one pulse is raised, and flush_full is 1 if any of the coinciding causes is full.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| wr_valid | input | 1 | Write strobe, accepted every cycle |
| wr_sel | input | 2 | Target register of the write |
| wr_data | input | 32 | Write value |
| sse_present | input | 1 | Configuration: 1 allows CR4 bit 9 to be stored |
| a20_gate | input | 1 | Level that enables address line 20 |
| rd_sel | input | 2 | Register selected for read-back |
| rd_data | output | 32 | Read-back value |
| a20_mask | output | 32 | Current A20 address mask |
| flush_pulse | output | 1 | One-cycle flush request |
| flush_full | output | 1 | Qualifier: 1 full flush, 0 non-global flush |
| hf_pe | output | 1 | Hidden protection-enable flag |
| hf_addseg | output | 1 | Hidden segment-base-add flag |
| hf_mp | output | 1 | Hidden monitor-coprocessor flag |
| hf_em | output | 1 | Hidden emulation flag |
| hf_ts | output | 1 | Hidden task-switched flag |
| hf_osfxsr | output | 1 | Hidden extended-state-save enable flag |

## Verification
The bench builds the unit with its default parameters: the CR0 reset value 0x60000010 and the gate on bit 20. These defaults make the reset-time state, the real-mode ADDSEG rule and the exact 0xFFEFFFFF mask value directly observable. With the defaults, every flush trigger bit can be toggled one at a time. The bench can also hold a CR3 write in the same cycle as a gate edge, which exercises the rule for merging full and non-global flush causes.

// File: rtl/pgctl_pkg.sv
package pgctl_pkg;
  localparam int unsigned XLEN = 32;

  typedef enum logic [1:0] {
    SEL_CR0 = 2'd0,
    SEL_CR3 = 2'd1,
    SEL_CR4 = 2'd2,
    SEL_AUX = 2'd3
  } pg_sel_e;

  // CR0 bit positions
  localparam int B0_PE = 0;
  localparam int B0_MP = 1;
  localparam int B0_EM = 2;
  localparam int B0_TS = 3;
  localparam int B0_ET = 4;
  localparam int B0_WP = 16;
  localparam int B0_PG = 31;

  // CR4 bit positions
  localparam int B4_PSE = 4;
  localparam int B4_PAE = 5;
  localparam int B4_PGE = 7;
  localparam int B4_XSV = 9;

  localparam logic [XLEN-1:0] CR0_FLUSH_MASK =
    (XLEN'(1) << B0_PG) | (XLEN'(1) << B0_WP) | (XLEN'(1) << B0_PE);
  localparam logic [XLEN-1:0] CR4_FLUSH_MASK =
    (XLEN'(1) << B4_PGE) | (XLEN'(1) << B4_PAE) | (XLEN'(1) << B4_PSE);

  typedef struct packed {
    logic req;
    logic full;
  } flush_req_t;
endpackage

// File: rtl/pgctl_cr0_reg.sv
module pgctl_cr0_reg
  import pgctl_pkg::*;
#(
  parameter logic [XLEN-1:0] RESET_VAL = 32'h6000_0010
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            we,
  input  logic [XLEN-1:0] wdata,
  output logic [XLEN-1:0] cr0_q,
  output logic            hf_pe,
  output logic            hf_addseg,
  output logic            hf_mp,
  output logic            hf_em,
  output logic            hf_ts,
  output flush_req_t      flush_o
);
  localparam logic [XLEN-1:0] ET_ONE = XLEN'(1) << B0_ET;

  logic [XLEN-1:0] stored_next;
  assign stored_next = wdata | ET_ONE;

  always_comb begin
    flush_o.req  = we && (|((wdata ^ cr0_q) & CR0_FLUSH_MASK));
    flush_o.full = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cr0_q     <= RESET_VAL;
      hf_pe     <= RESET_VAL[B0_PE];
      hf_addseg <= ~RESET_VAL[B0_PE];
      hf_mp     <= RESET_VAL[B0_MP];
      hf_em     <= RESET_VAL[B0_EM];
      hf_ts     <= RESET_VAL[B0_TS];
    end else if (we) begin
      cr0_q     <= stored_next;
      hf_pe     <= stored_next[B0_PE];
      hf_addseg <= ~stored_next[B0_PE];
      hf_mp     <= wdata[B0_MP];
      hf_em     <= wdata[B0_EM];
      hf_ts     <= wdata[B0_TS];
    end
  end

  // R5: real mode always adds segment bases
  a_r5_addseg_real: assert property (@(posedge clk) disable iff (!rst_n)
    !hf_pe |-> hf_addseg);

  // R6: FPU-related flags follow the written data bits
  a_r6_fpu_flags: assert property (@(posedge clk) disable iff (!rst_n)
    we |=> ({hf_ts, hf_em, hf_mp} == $past(wdata[B0_TS:B0_MP])));
endmodule

// File: rtl/pgctl_cr4_reg.sv
module pgctl_cr4_reg
  import pgctl_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic            we,
  input  logic [XLEN-1:0] wdata,
  input  logic            sse_present,
  output logic [XLEN-1:0] cr4_q,
  output logic            hf_osfxsr,
  output flush_req_t      flush_o
);
  localparam logic [XLEN-1:0] XSV_ONE = XLEN'(1) << B4_XSV;

  logic [XLEN-1:0] wdata_eff;
  assign wdata_eff = sse_present ? wdata : (wdata & ~XSV_ONE);

  always_comb begin
    flush_o.req  = we && (|((wdata_eff ^ cr4_q) & CR4_FLUSH_MASK));
    flush_o.full = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cr4_q     <= '0;
      hf_osfxsr <= 1'b0;
    end else if (we) begin
      cr4_q     <= wdata_eff;
      hf_osfxsr <= wdata_eff[B4_XSV];
    end
  end

  // R9: without SSE support the save-enable bit never sticks
  a_r9_xsv_masked: assert property (@(posedge clk) disable iff (!rst_n)
    (we && !sse_present) |=> (!cr4_q[B4_XSV] && !hf_osfxsr));
endmodule

// File: rtl/pgctl_a20_gate.sv
module pgctl_a20_gate
  import pgctl_pkg::*;
#(
  parameter int unsigned GATE_BIT = 20
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            gate,
  output logic [XLEN-1:0] mask_q,
  output flush_req_t      flush_o
);
  localparam logic [XLEN-1:0] GATE_ONE = XLEN'(1) << GATE_BIT;

  logic changed;
  assign changed = (gate != mask_q[GATE_BIT]);

  always_comb begin
    flush_o.req  = changed;
    flush_o.full = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mask_q <= '1;
    end else if (changed) begin
      mask_q <= ~GATE_ONE | (gate ? GATE_ONE : '0);
    end
  end

  // R10: the gated bit takes the new gate level one cycle after a change
  a_r10_mask_follows: assert property (@(posedge clk) disable iff (!rst_n)
    changed |=> (mask_q[GATE_BIT] == $past(gate)));
endmodule

// File: rtl/pgctl_flush_merge.sv
module pgctl_flush_merge
  import pgctl_pkg::*;
#(
  parameter int unsigned NSRC = 4
) (
  input  logic       clk,
  input  logic       rst_n,
  input  flush_req_t src [NSRC],
  output logic       flush_pulse,
  output logic       flush_full
);
  logic [NSRC-1:0] req_v;
  logic [NSRC-1:0] full_v;

  for (genvar g = 0; g < NSRC; g++) begin : g_unpack
    assign req_v[g]  = src[g].req;
    assign full_v[g] = src[g].req & src[g].full;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flush_pulse <= 1'b0;
      flush_full  <= 1'b0;
    end else begin
      flush_pulse <= |req_v;
      flush_full  <= |full_v;
    end
  end

  // R11: the qualifier is only meaningful alongside a pulse
  a_r11_qual_with_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    flush_full |-> flush_pulse);
endmodule

// File: rtl/paging_ctrl_regs.sv
module paging_ctrl_regs
  import pgctl_pkg::*;
#(
  parameter logic [31:0] CR0_RESET = 32'h6000_0010,
  parameter int unsigned A20_BIT   = 20
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        wr_valid,
  input  logic [1:0]  wr_sel,
  input  logic [31:0] wr_data,
  input  logic        sse_present,
  input  logic        a20_gate,
  input  logic [1:0]  rd_sel,
  output logic [31:0] rd_data,
  output logic [31:0] a20_mask,
  output logic        flush_pulse,
  output logic        flush_full,
  output logic        hf_pe,
  output logic        hf_addseg,
  output logic        hf_mp,
  output logic        hf_em,
  output logic        hf_ts,
  output logic        hf_osfxsr
);
  localparam int unsigned NSRC = 4;
  localparam int unsigned S_CR0 = 0;
  localparam int unsigned S_CR3 = 1;
  localparam int unsigned S_CR4 = 2;
  localparam int unsigned S_A20 = 3;

  logic            we0, we3, we4;
  logic [XLEN-1:0] cr0_q, cr3_q, cr4_q;
  flush_req_t      srcs [NSRC];

  assign we0 = wr_valid && (wr_sel == SEL_CR0);
  assign we3 = wr_valid && (wr_sel == SEL_CR3);
  assign we4 = wr_valid && (wr_sel == SEL_CR4);

  pgctl_cr0_reg #(.RESET_VAL(CR0_RESET)) u_cr0 (
    .clk(clk), .rst_n(rst_n), .we(we0), .wdata(wr_data),
    .cr0_q(cr0_q), .hf_pe(hf_pe), .hf_addseg(hf_addseg),
    .hf_mp(hf_mp), .hf_em(hf_em), .hf_ts(hf_ts),
    .flush_o(srcs[S_CR0])
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cr3_q <= '0;
    else if (we3) cr3_q <= wr_data;
  end

  always_comb begin
    srcs[S_CR3].req  = we3 && cr0_q[B0_PG];
    srcs[S_CR3].full = 1'b0;
  end

  pgctl_cr4_reg u_cr4 (
    .clk(clk), .rst_n(rst_n), .we(we4), .wdata(wr_data),
    .sse_present(sse_present), .cr4_q(cr4_q), .hf_osfxsr(hf_osfxsr),
    .flush_o(srcs[S_CR4])
  );

  pgctl_a20_gate #(.GATE_BIT(A20_BIT)) u_a20 (
    .clk(clk), .rst_n(rst_n), .gate(a20_gate), .mask_q(a20_mask),
    .flush_o(srcs[S_A20])
  );

  pgctl_flush_merge #(.NSRC(NSRC)) u_merge (
    .clk(clk), .rst_n(rst_n), .src(srcs),
    .flush_pulse(flush_pulse), .flush_full(flush_full)
  );

  always_comb begin
    unique case (pg_sel_e'(rd_sel))
      SEL_CR0: rd_data = cr0_q;
      SEL_CR3: rd_data = cr3_q;
      SEL_CR4: rd_data = cr4_q;
      default: rd_data = a20_mask;
    endcase
  end

  // R4: a CR0 change on a paging trigger bit requests a full flush
  a_r4_cr0_flush: assert property (@(posedge clk) disable iff (!rst_n)
    (we0 && (|((wr_data ^ cr0_q) & CR0_FLUSH_MASK))) |=> (flush_pulse && flush_full));

  // R7: a CR3 write under paging asks for a non-global flush
  a_r7_cr3_flush: assert property (@(posedge clk) disable iff (!rst_n)
    (we3 && cr0_q[B0_PG] && (a20_gate == a20_mask[A20_BIT])) |=> (flush_pulse && !flush_full));

  // R8: a CR4 change on a page-format bit requests a full flush
  a_r8_cr4_flush: assert property (@(posedge clk) disable iff (!rst_n)
    (we4 && (|((wr_data ^ cr4_q) & CR4_FLUSH_MASK))) |=> (flush_pulse && flush_full));

  // R12: a gate edge coinciding with anything still yields a full flush
  a_r12_merge_full: assert property (@(posedge clk) disable iff (!rst_n)
    (a20_gate != a20_mask[A20_BIT]) |=> (flush_pulse && flush_full));
endmodule

// File: tb/sim_paging_ctrl_regs.sv
`timescale 1ns/1ps
module sim_paging_ctrl_regs;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_valid = 1'b0;
  logic [1:0]  wr_sel = 2'd0;
  logic [31:0] wr_data = '0;
  logic        sse_present = 1'b1;
  logic        a20_gate = 1'b1;
  logic [1:0]  rd_sel = 2'd0;
  logic [31:0] rd_data, a20_mask;
  logic        flush_pulse, flush_full;
  logic        hf_pe, hf_addseg, hf_mp, hf_em, hf_ts, hf_osfxsr;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  paging_ctrl_regs u0 (
    .clk(clk), .rst_n(rst_n), .wr_valid(wr_valid), .wr_sel(wr_sel),
    .wr_data(wr_data), .sse_present(sse_present), .a20_gate(a20_gate),
    .rd_sel(rd_sel), .rd_data(rd_data), .a20_mask(a20_mask),
    .flush_pulse(flush_pulse), .flush_full(flush_full),
    .hf_pe(hf_pe), .hf_addseg(hf_addseg), .hf_mp(hf_mp), .hf_em(hf_em),
    .hf_ts(hf_ts), .hf_osfxsr(hf_osfxsr)
  );

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      failures++;
      $display("FAIL %s: got 0x%08h expected 0x%08h", tag, got, exp);
    end
  endtask

  task automatic rd(input logic [1:0] sel, output logic [31:0] val);
    rd_sel = sel;
    #0.5;
    val = rd_data;
  endtask

  // drive one write; returns just after the sampling edge (at the next negedge)
  task automatic wr(input logic [1:0] sel, input logic [31:0] data);
    @(negedge clk);
    wr_valid = 1'b1; wr_sel = sel; wr_data = data;
    @(negedge clk);
    wr_valid = 1'b0;
  endtask

  task automatic chk_flush(input string tag, input logic p, input logic f);
    chk({tag, " pulse"}, {31'b0, flush_pulse}, {31'b0, p});
    if (p) chk({tag, " full"}, {31'b0, flush_full}, {31'b0, f});
  endtask

  task automatic t_reset();
    logic [31:0] v;
    chk_flush("R1 reset", 1'b0, 1'b0);
    rd(2'd0, v); chk("R1 cr0", v, 32'h6000_0010);
    rd(2'd1, v); chk("R1 cr3", v, 32'h0);
    rd(2'd2, v); chk("R1 cr4", v, 32'h0);
    rd(2'd3, v); chk("R1 mask via read", v, 32'hFFFF_FFFF);
    chk("R1 mask", a20_mask, 32'hFFFF_FFFF);
    chk("R1 flags", {26'b0, hf_pe, hf_addseg, hf_mp, hf_em, hf_ts, hf_osfxsr},
        32'b01_0000);
  endtask

  task automatic t_cr0();
    logic [31:0] v;
    wr(2'd0, 32'h0000_000E);
    chk_flush("R11 cr0 quiet", 1'b0, 1'b0);
    rd(2'd0, v); chk("R3 et forced", v, 32'h0000_001E);
    chk("R6 mp/em/ts set", {29'b0, hf_mp, hf_em, hf_ts}, 32'h7);
    chk("R5 real mode", {30'b0, hf_pe, hf_addseg}, 32'b01);
    wr(2'd0, 32'h8001_0001);
    chk_flush("R4 cr0 trig", 1'b1, 1'b1);
    rd(2'd0, v); chk("R3 cr0 rb", v, 32'h8001_0011);
    chk("R5 prot mode", {30'b0, hf_pe, hf_addseg}, 32'b10);
    chk("R6 mp/em/ts clear", {29'b0, hf_mp, hf_em, hf_ts}, 32'h0);
    @(negedge clk);
    chk_flush("R11 one cycle", 1'b0, 1'b0);
  endtask

  task automatic t_cr3();
    logic [31:0] v;
    wr(2'd1, 32'h1234_5000);
    chk_flush("R7 cr3 paged", 1'b1, 1'b0);
    rd(2'd1, v); chk("R2 cr3 rb", v, 32'h1234_5000);
    wr(2'd0, 32'h0000_0001);
    chk_flush("R4 pg drop", 1'b1, 1'b1);
    wr(2'd1, 32'hABCD_0000);
    chk_flush("R7 cr3 unpaged", 1'b0, 1'b0);
    rd(2'd1, v); chk("R2 cr3 rb2", v, 32'hABCD_0000);
  endtask

  task automatic t_cr4();
    logic [31:0] v;
    wr(2'd2, 32'h0000_0200);
    chk_flush("R11 cr4 quiet", 1'b0, 1'b0);
    chk("R9 flag on", {31'b0, hf_osfxsr}, 32'h1);
    wr(2'd2, 32'h0000_0220);
    chk_flush("R8 pae", 1'b1, 1'b1);
    wr(2'd2, 32'h0000_0120);
    chk_flush("R8 bit8 only", 1'b0, 1'b0);
    chk("R9 flag off", {31'b0, hf_osfxsr}, 32'h0);
    sse_present = 1'b0;
    wr(2'd2, 32'h0000_02A0);
    chk_flush("R8 pge", 1'b1, 1'b1);
    rd(2'd2, v); chk("R9 masked store", v, 32'h0000_00A0);
    chk("R9 flag masked", {31'b0, hf_osfxsr}, 32'h0);
    sse_present = 1'b1;
  endtask

  task automatic t_a20();
    @(negedge clk); a20_gate = 1'b0;
    @(negedge clk);
    chk_flush("R10 gate off", 1'b1, 1'b1);
    chk("R10 mask off", a20_mask, 32'hFFEF_FFFF);
    @(negedge clk);
    chk_flush("R10 steady", 1'b0, 1'b0);
    chk("R10 mask held", a20_mask, 32'hFFEF_FFFF);
    a20_gate = 1'b1;
    @(negedge clk);
    chk_flush("R10 gate on", 1'b1, 1'b1);
    chk("R10 mask on", a20_mask, 32'hFFFF_FFFF);
  endtask

  task automatic t_sel3();
    logic [31:0] v;
    wr(2'd3, 32'h0000_0000);
    chk_flush("R2 sel3 no flush", 1'b0, 1'b0);
    rd(2'd0, v); chk("R2 sel3 cr0", v, 32'h0000_0011);
    rd(2'd1, v); chk("R2 sel3 cr3", v, 32'hABCD_0000);
    rd(2'd2, v); chk("R2 sel3 cr4", v, 32'h0000_00A0);
    chk("R2 sel3 mask", a20_mask, 32'hFFFF_FFFF);
  endtask

  task automatic t_merge();
    wr(2'd0, 32'h8000_0001);
    chk_flush("R4 pg on", 1'b1, 1'b1);
    @(negedge clk);
    wr_valid = 1'b1; wr_sel = 2'd1; wr_data = 32'h0000_3000; a20_gate = 1'b0;
    @(negedge clk);
    wr_valid = 1'b0;
    chk_flush("R12 merged", 1'b1, 1'b1);
    @(negedge clk);
    chk_flush("R12 single", 1'b0, 1'b0);
    a20_gate = 1'b1;
    @(negedge clk);
    chk_flush("R10 restore", 1'b1, 1'b1);
  endtask

  initial begin
    #10000;
    if (!done) begin
      failures++;
      $display("FAIL watchdog: got hang expected completion");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_cr0();
    t_cr3();
    t_cr4();
    t_a20();
    t_sel3();
    t_merge();
    done = 1'b1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule